// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block is the host end of a link to a disk adapter that hangs off a parallel port. It drives an 8-bit data bus and a 4-bit control bus toward the adapter and watches the 8-bit status bus coming back. A single request names one adapter register through a bank select bit and a 3-bit index. The request also says whether to read or write and, for a write, carries the byte to store. The engine then plays out a fixed series of control and data steps to latch the register address and move one byte.

Every step on the port is held for a programmable number of clock cycles, so the same engine can drive slow or fast cables. A read brings back its byte four bits at a time: two status samples are taken, and the upper half of each one is used. A write puts the byte on the data bus and pulses the control lines. When the last step is finished the engine raises a one-cycle done pulse and becomes ready for the next request.

Top module: `pport_reg_seq`

## Requirements
- R1: After reset the control bus is 0x4, the data bus is 0x00, ready is high, done is low and read data is 0x00.
- R2: An accepted request first writes control 0x4 and then, in the next step, puts the port address on the data bus. The port address is the index plus 0x08 when select is 0, or the index plus 0x10 when select is 1. The data bus keeps its previous value during the first step.
- R3: After the address step, control takes the values 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4, one per step.
- R4: A read follows the address strobe with three control steps: 0x6, then 0x4, then a final 0x4. Status is sampled at the end of the 0x6 step (the low sample) and at the end of the following 0x4 step (the high sample).
- R5: Read data is {high sample[7:4], low sample[7:4]}. It is updated when a read completes and holds its value until the next read completes.
- R6: A write follows the address strobe with a data step that puts the write byte on the data bus, then control steps 0x5, 0x7, 0x5, 0x4.
- R7: Each step holds its bus values for exactly delay+1 clock cycles. Bus outputs change only at step boundaries.
- R8: A request is taken only while ready is high. Ready drops for the whole access. A request presented while ready is low has no effect on the buses, on read data or on the number of done pulses.
- R9: Done is high for exactly one cycle, and ready returns high in that same cycle. For an access accepted at clock edge E, done rises after edge E + 12*(delay+1) for a read, or after edge E + 14*(delay+1) for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay | input | DW | Extra hold cycles per port step |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Bank select: 0 = register file, 1 = command set |
| req_idx | input | 3 | Register index within the bank |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Engine idle and able to take a request |
| done | output | 1 | One-cycle pulse when an access completes |
| rdata | output | 8 | Byte returned by the last read |
| pd_out | output | 8 | Parallel data bus |
| pc_out | output | 4 | Parallel control bus |
| ps_in | input | 8 | Parallel status bus |

## Verification
The assertions assume that delay stays constant while an access is in flight. The hold-length property compares neighbouring cycles and depends on that. They also assume the status bus only needs to be valid at the sampling edges. The bench changes delay only while ready is high. It drives status from a model that follows the control bus, returning a distinct value while control is 0x6. Requests raised during a busy access carry values different from the access in flight, so that any effect they had would show on the buses.

// File: rtl/pport_reg_seq.sv
module pport_reg_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] delay,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_sel,
  input  logic [2:0]    req_idx,
  input  logic [7:0]    req_wdata,
  output logic          ready,
  output logic          done,
  output logic [7:0]    rdata,
  output logic [7:0]    pd_out,
  output logic [3:0]    pc_out,
  input  logic [7:0]    ps_in
);

  localparam logic [3:0] RD_LAST = 4'd11;
  localparam logic [3:0] WR_LAST = 4'd13;
  localparam logic [3:0] RD_LO   = 4'd9;
  localparam logic [3:0] RD_HI   = 4'd10;

  logic          busy;
  logic          op_wr;
  logic [7:0]    addr_q;
  logic [7:0]    wdat_q;
  logic [3:0]    step;
  logic [DW-1:0] hold;
  logic [3:0]    lo_nib;

  logic          hold_end;
  logic          last_step;
  logic          a_wr;
  logic [3:0]    a_step;
  logic [7:0]    a_addr;
  logic [7:0]    a_wdat;
  logic          a_has_c;
  logic [3:0]    a_c;
  logic          a_has_d;
  logic [7:0]    a_d;
  logic [7:0]    new_addr;

  assign ready     = !busy;
  assign hold_end  = (hold == delay);
  assign last_step = op_wr ? (step == WR_LAST) : (step == RD_LAST);
  assign new_addr  = {5'd0, req_idx} + (req_sel ? 8'h10 : 8'h08);

  assign a_wr   = busy ? op_wr  : req_write;
  assign a_step = busy ? step + 4'd1 : 4'd0;
  assign a_addr = busy ? addr_q : new_addr;
  assign a_wdat = busy ? wdat_q : req_wdata;

  always_comb begin
    a_has_c = 1'b0;
    a_c     = 4'h4;
    a_has_d = 1'b0;
    a_d     = 8'h00;
    case (a_step)
      4'd0: begin a_has_c = 1'b1; a_c = 4'h4; end
      4'd1: begin a_has_d = 1'b1; a_d = a_addr; end
      4'd2: begin a_has_c = 1'b1; a_c = 4'hC; end
      4'd3: begin a_has_c = 1'b1; a_c = 4'hE; end
      4'd4: begin a_has_c = 1'b1; a_c = 4'hE; end
      4'd5: begin a_has_c = 1'b1; a_c = 4'hC; end
      4'd6, 4'd7, 4'd8: begin a_has_c = 1'b1; a_c = 4'h4; end
      4'd9: begin
        if (a_wr) begin a_has_d = 1'b1; a_d = a_wdat; end
        else begin a_has_c = 1'b1; a_c = 4'h6; end
      end
      4'd10: begin a_has_c = 1'b1; a_c = a_wr ? 4'h5 : 4'h4; end
      4'd11: begin a_has_c = 1'b1; a_c = a_wr ? 4'h7 : 4'h4; end
      4'd12: begin a_has_c = 1'b1; a_c = 4'h5; end
      4'd13: begin a_has_c = 1'b1; a_c = 4'h4; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      op_wr  <= 1'b0;
      addr_q <= 8'h00;
      wdat_q <= 8'h00;
      step   <= 4'd0;
      hold   <= '0;
      lo_nib <= 4'h0;
      done   <= 1'b0;
      rdata  <= 8'h00;
      pd_out <= 8'h00;
      pc_out <= 4'h4;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          op_wr  <= req_write;
          addr_q <= new_addr;
          wdat_q <= req_wdata;
          step   <= 4'd0;
          hold   <= '0;
          if (a_has_c) pc_out <= a_c;
          if (a_has_d) pd_out <= a_d;
        end
      end else if (!hold_end) begin
        hold <= hold + 1'b1;
      end else begin
        hold <= '0;
        if (!op_wr && step == RD_LO) lo_nib <= ps_in[7:4];
        if (!op_wr && step == RD_HI) rdata <= {ps_in[7:4], lo_nib};
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 4'd1;
          if (a_has_c) pc_out <= a_c;
          if (a_has_d) pd_out <= a_d;
        end
      end
    end
  end

endmodule

// File: rtl/pport_reg_seq_chk.sv
module pport_reg_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] delay,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_sel,
  input logic [2:0]    req_idx,
  input logic [7:0]    req_wdata,
  input logic          ready,
  input logic          done,
  input logic [7:0]    rdata,
  input logic [7:0]    pd_out,
  input logic [3:0]    pc_out,
  input logic [7:0]    ps_in
);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  a_r8_idle_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req_valid) |=> $stable(pd_out) && $stable(rdata));

  a_r4_idle_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> pc_out == 4'h4);

  a_r3_ctrl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hC, 4'hE});

  a_r7_hold_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && delay != '0 && pc_out != $past(pc_out)) |=> $stable(pc_out));

  a_r5_rdata_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != $past(rdata)) |-> !ready);

endmodule

bind pport_reg_seq pport_reg_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pport_reg_seq.sv
`timescale 1ns/1ps
module tb_pport_reg_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] delay;
  logic       req_valid;
  logic       req_write;
  logic       req_sel;
  logic [2:0] req_idx;
  logic [7:0] req_wdata;
  logic       ready;
  logic       done;
  logic [7:0] rdata;
  logic [7:0] pd_out;
  logic [3:0] pc_out;
  logic [7:0] ps_in;
  logic [7:0] st_lo;
  logic [7:0] st_hi;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  assign ps_in = (pc_out == 4'h6) ? st_lo : st_hi;

  pport_reg_seq #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .delay(delay),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_idx(req_idx), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rdata(rdata),
    .pd_out(pd_out), .pc_out(pc_out), .ps_in(ps_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sel, input logic [2:0] idx,
                        input logic [7:0] wd, input logic [7:0] lo,
                        input logic [7:0] hi, input int d, input bit poke);
    int nst;
    int total;
    int ec[14];
    int ed[14];
    int bad_addr = 0, bad_strb = 0, bad_tail = 0, bad_hold = 0;
    int bad_busy = 0, done_at = -1, done_cnt = 0;
    int cur_c, cur_d;
    logic [3:0] pc_prev;
    logic [7:0] pd_prev;
    logic [7:0] addr;
    nst   = wr ? 14 : 12;
    total = nst * (d + 1);
    addr  = {5'd0, idx} + (sel ? 8'h10 : 8'h08);
    cur_c = 4; cur_d = pd_out;
    for (int s = 0; s < nst; s++) begin
      case (s)
        0: cur_c = 4;
        1: cur_d = addr;
        2: cur_c = 'hC;
        3: cur_c = 'hE;
        4: cur_c = 'hE;
        5: cur_c = 'hC;
        6, 7, 8: cur_c = 4;
        9: if (wr) cur_d = wd; else cur_c = 6;
        10: cur_c = wr ? 5 : 4;
        11: cur_c = wr ? 7 : 4;
        12: cur_c = 5;
        default: cur_c = 4;
      endcase
      ec[s] = cur_c; ed[s] = cur_d;
    end
    st_lo = lo; st_hi = hi;
    delay = d[7:0];
    req_write = wr; req_sel = sel; req_idx = idx; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    pc_prev = pc_out; pd_prev = pd_out;
    for (int j = 0; j <= total; j++) begin
      int s;
      s = (j < total) ? j / (d + 1) : nst - 1;
      if (s <= 1) begin
        if (pc_out != ec[s][3:0] || pd_out != ed[s][7:0]) bad_addr++;
      end else if (s <= 8) begin
        if (pc_out != ec[s][3:0] || pd_out != ed[s][7:0]) bad_strb++;
      end else begin
        if (pc_out != ec[s][3:0] || pd_out != ed[s][7:0]) bad_tail++;
      end
      if (j > 0 && (j % (d + 1)) != 0 &&
          (pc_out != pc_prev || pd_out != pd_prev)) bad_hold++;
      if (j < total && ready) bad_busy++;
      if (done) begin done_cnt++; done_at = j; end
      pc_prev = pc_out; pd_prev = pd_out;
      if (poke && j == 2) begin
        req_write = ~wr; req_sel = ~sel; req_idx = ~idx; req_wdata = ~wd;
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk(bad_addr == 0, "R2", "address phase mismatches", bad_addr, 0);
    chk(bad_strb == 0, "R3", "strobe phase mismatches", bad_strb, 0);
    chk(bad_tail == 0, wr ? "R6" : "R4", "tail phase mismatches", bad_tail, 0);
    chk(bad_hold == 0, "R7", "changes inside a step", bad_hold, 0);
    chk(bad_busy == 0, "R8", "ready high while busy", bad_busy, 0);
    chk(done_at == total && done_cnt == 1, "R9", "done cycle", done_at, total);
    chk(done == 1'b0 && ready == 1'b1 && pc_out == 4'h4, "R9",
        "done cleared / idle after", {done, ready, pc_out}, 6'b010100);
    if (!wr) last_rd = {hi[7:4], lo[7:4]};
    chk(rdata == last_rd, "R5", "read data", rdata, last_rd);
  endtask

  task automatic t_reset;
    chk(pc_out == 4'h4, "R1", "reset control", pc_out, 4);
    chk(pd_out == 8'h00, "R1", "reset data", pd_out, 0);
    chk(ready == 1'b1 && done == 1'b0, "R1", "reset ready/done", {ready, done}, 2'b10);
    chk(rdata == 8'h00, "R1", "reset rdata", rdata, 0);
  endtask

  task automatic t_reads;
    access(1'b0, 1'b0, 3'd5, 8'h00, 8'h3A, 8'hC5, 0, 1'b0);
    access(1'b0, 1'b1, 3'd7, 8'h00, 8'hF0, 8'h0F, 1, 1'b0);
    access(1'b0, 1'b0, 3'd0, 8'h00, 8'h90, 8'h6F, 3, 1'b0);
  endtask

  task automatic t_writes;
    access(1'b1, 1'b0, 3'd2, 8'hA5, 8'h00, 8'hFF, 0, 1'b0);
    access(1'b1, 1'b1, 3'd0, 8'h3C, 8'h11, 8'h22, 2, 1'b0);
  endtask

  task automatic t_busy_ignore;
    access(1'b0, 1'b1, 3'd3, 8'h00, 8'h7E, 8'hB1, 1, 1'b1);
    access(1'b1, 1'b0, 3'd6, 8'h5A, 8'h00, 8'h00, 0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; delay = 8'd0; req_valid = 1'b0; req_write = 1'b0;
    req_sel = 1'b0; req_idx = 3'd0; req_wdata = 8'h00;
    st_lo = 8'h00; st_hi = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_writes();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule